// File: doc/BRIEF.md
# Nibble-Bus Command Register Interface

This block is the device-side host port of a character display controller. The host data bus is only four bits wide, but every code the controller takes is eight bits. The host therefore writes each code as two nibbles: the upper half first, then the lower half. The block keeps the upper half in a holding register. When the lower half arrives, it presents the full byte for one cycle, marked as character data or as a command. The register-select level seen on the lower-half write alone picks which of the two it is.

After each completed byte, the block holds a busy flag for a fixed worst-case execution window. The host can read this flag with one read strobe. A write that arrives during the window is dropped, and a sticky error flag records the drop. Command decoding and display memory sit downstream, fed by the byte strobe.

Top module: `nibble_cmd_if`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `err_flag`, `byte_vld` and `host_rdata` are all 0, and the next accepted write is taken as an upper nibble.
- R2: The first accepted write of a pair stores `host_wdata` as bits 7..4 and raises no `byte_vld`.
- R3: The second accepted write of a pair makes `byte_out` equal to {stored upper nibble, `host_wdata`}. `byte_vld` is 1 for exactly one cycle, the cycle right after that write's clock edge.
- R4: `byte_is_cmd` equals the `host_sel` level sampled on the lower-nibble write (1 = command register, 0 = character register). The `host_sel` level on the upper-nibble write has no effect.
- R5: A read strobe `host_rd` yields `host_rdata` = {busy, 3'b000} in the next cycle, with busy on bit 3 taken as it stood at the strobe edge. Without a strobe, `host_rdata` is 0. A read between the two nibbles does not break the pair.
- R6: `busy` rises in the cycle right after a lower-nibble write and stays high for exactly BUSY_CYCLES (default 16) cycles.
- R7: `busy` stays low while an upper nibble is held, however long the host waits before the lower nibble.
- R8: A write while `busy` is 1 is ignored. It produces no `byte_vld` and does not advance the nibble phase.
- R9: An ignored write sets `err_flag` in the next cycle. `err_flag` then stays 1 until reset.
- R10: After each completed byte the phase returns to expecting an upper nibble, so successive pairs assemble independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Nibble write strobe, one cycle per nibble |
| host_rd | input | 1 | Status read strobe |
| host_sel | input | 1 | Register select: 1 command, 0 character |
| host_wdata | input | 4 | Write nibble |
| host_rdata | output | 4 | Status nibble, busy on bit 3 |
| byte_out | output | 8 | Assembled byte |
| byte_vld | output | 1 | One-cycle strobe for `byte_out` |
| byte_is_cmd | output | 1 | Destination of the presented byte |
| busy | output | 1 | Execution window in progress |
| err_flag | output | 1 | Sticky flag for a write dropped while busy |

## Verification
If the nibble phase ends up in the wrong state, the byte pairing slips. The next byte then comes out with its halves swapped, or it does not appear at all. This shows on `byte_out` and `byte_vld` within one pair of writes. A wrong busy counter changes the length of the window. The bench measures that length cycle by cycle, so a difference of a single cycle shows, as does a dropped write that should have been accepted. A lost or cleared error bit shows on `err_flag` in the cycle after the offending write, or at any later check.

// File: rtl/nibcmd_pkg.sv
// Shared types for the nibble-bus command interface.
// Assumes: nothing beyond SystemVerilog enum support.
package nibcmd_pkg;
    // Destination of an assembled byte, taken from the select line.
    typedef enum logic {
        DEST_CHAR = 1'b0,
        DEST_CMD  = 1'b1
    } dest_e;

    // Which half of a byte the next accepted write supplies.
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;
endpackage

// File: rtl/nib_assembler.sv
// Pairs accepted nibble writes into bytes, upper half first.
// Assumes: wr_acc already excludes writes made while busy.
module nib_assembler
    import nibcmd_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_acc,
    input  logic [NIB_W-1:0]   wdata,
    input  logic               sel,
    output logic [2*NIB_W-1:0] byte_out,
    output logic               byte_vld,
    output logic               to_cmd,
    output logic               hi_pending,
    output logic               done
);
    localparam int BYTE_W = 2 * NIB_W;

    phase_e            phase_q;
    logic [NIB_W-1:0]  hi_q;
    logic [BYTE_W-1:0] byte_q;
    logic              vld_q;
    dest_e             dest_q;

    assign done = wr_acc && (phase_q == PH_LOW);

    // Toggle the phase on every accepted write; return to high after a byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= PH_HIGH;
        else if (wr_acc)   phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
    end

    // Hold the upper nibble until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                             hi_q <= '0;
        else if (wr_acc && phase_q == PH_HIGH)  hi_q <= wdata;
    end

    // Form the byte and latch the destination on the lower-nibble write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            dest_q <= DEST_CHAR;
        end else if (done) begin
            byte_q <= {hi_q, wdata};
            dest_q <= sel ? DEST_CMD : DEST_CHAR;
        end
    end

    // One-cycle strobe following each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= done;
    end

    assign byte_out   = byte_q;
    assign byte_vld   = vld_q;
    assign to_cmd     = (dest_q == DEST_CMD);
    assign hi_pending = (phase_q == PH_LOW);

    // R2: an upper-nibble write never yields a strobe.
    a_r2_no_vld_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !hi_pending) |=> !byte_vld);
    // R3: a lower-nibble write yields a strobe next cycle.
    a_r3_vld_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && hi_pending) |=> byte_vld);
    // R10: after a completed byte the next write is an upper nibble.
    a_r10_phase_back: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !hi_pending);
endmodule

// File: rtl/busy_timer.sv
// Holds busy for a fixed number of cycles after each completed byte.
// Assumes: start is never raised while busy is already high.
module busy_timer #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R6: busy follows every start.
    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R6: the window never exceeds its bound.
    a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
endmodule

// File: rtl/status_read.sv
// Returns the busy flag on a one-cycle read and keeps the sticky error bit.
// Assumes: busy bit sits at the top of the data nibble.
module status_read #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic             busy,
    input  logic             dropped,
    output logic [NIB_W-1:0] rdata,
    output logic             err
);
    localparam int BUSY_BIT = NIB_W - 1;

    logic [NIB_W-1:0] rdata_q;
    logic             err_q;

    // Capture busy into the read nibble on a strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else begin
            rdata_q <= '0;
            if (rd) rdata_q[BUSY_BIT] <= busy;
        end
    end

    // Set the error bit on any dropped write; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (dropped) err_q <= 1'b1;
    end

    assign rdata = rdata_q;
    assign err   = err_q;

    // R5: a read returns the busy value of its strobe cycle.
    a_r5_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (rdata[BUSY_BIT] == $past(busy)));
    // R5: no strobe, no data.
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0));
    // R9: the error bit is sticky.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R9: a dropped write sets the error bit.
    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> err);
endmodule

// File: rtl/nibble_cmd_if.sv
// Top of the nibble-bus host port: gates writes by busy, assembles
// bytes, times the execution window and serves status reads.
// Assumes: host strobes are synchronous to clk and one cycle wide.
module nibble_cmd_if #(
    parameter int NIB_W       = 4,
    parameter int BUSY_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic               host_sel,
    input  logic [NIB_W-1:0]   host_wdata,
    output logic [NIB_W-1:0]   host_rdata,
    output logic [2*NIB_W-1:0] byte_out,
    output logic               byte_vld,
    output logic               byte_is_cmd,
    output logic               busy,
    output logic               err_flag
);
    logic wr_acc;
    logic dropped;
    logic done;
    logic hi_pending;

    assign wr_acc  = host_wr && !busy;
    assign dropped = host_wr &&  busy;

    nib_assembler #(.NIB_W(NIB_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wdata(host_wdata),
        .sel(host_sel), .byte_out(byte_out), .byte_vld(byte_vld),
        .to_cmd(byte_is_cmd), .hi_pending(hi_pending), .done(done)
    );

    busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(done), .busy(busy)
    );

    status_read #(.NIB_W(NIB_W)) u_sts (
        .clk(clk), .rst_n(rst_n), .rd(host_rd), .busy(busy),
        .dropped(dropped), .rdata(host_rdata), .err(err_flag)
    );

    // R7: never busy while an upper nibble waits.
    a_r7_no_busy_mid: assert property (@(posedge clk) disable iff (!rst_n)
        hi_pending |-> !busy);
    // R8: a write during busy produces no byte.
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && busy) |=> !byte_vld);
    // R3: the strobe is a single cycle.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

// File: tb/sim_nibble_cmd_if.sv
module sim_nibble_cmd_if;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_wr, host_rd, host_sel;
    logic [3:0] host_wdata;
    logic [3:0] host_rdata;
    logic [7:0] byte_out;
    logic       byte_vld, byte_is_cmd, busy, err_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nibble_cmd_if u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .byte_out(byte_out), .byte_vld(byte_vld), .byte_is_cmd(byte_is_cmd),
        .busy(busy), .err_flag(err_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; host_wr = 0; host_rd = 0; host_sel = 0; host_wdata = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive one nibble write; returns one negedge after its clock edge.
    task automatic wr_nib(input logic [3:0] nib, input logic sel);
        host_wr = 1'b1; host_wdata = nib; host_sel = sel;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 err", err_flag, 0);
        check("R1 vld", byte_vld, 0);
        check("R1 rdata", host_rdata, 0);
    endtask

    task automatic t_pair_cmd();
        wr_nib(4'hA, 1'b0);
        check("R2 no vld on high", byte_vld, 0);
        repeat (5) @(negedge clk);
        check("R7 idle between nibbles", busy, 0);
        wr_nib(4'h5, 1'b1);
        check("R3 vld", byte_vld, 1);
        check("R3 byte", byte_out, 8'hA5);
        check("R4 dest cmd", byte_is_cmd, 1);
        check("R6 busy rises", busy, 1);
        @(negedge clk);
        check("R3 single pulse", byte_vld, 0);
        wait_idle();
    endtask

    task automatic t_pair_char();
        wr_nib(4'h7, 1'b1);
        wr_nib(4'h2, 1'b0);
        check("R3 byte char", byte_out, 8'h72);
        check("R4 dest from low nibble", byte_is_cmd, 0);
        wait_idle();
    endtask

    task automatic t_busy_len();
        int n = 0;
        wr_nib(4'h1, 1'b1);
        wr_nib(4'h0, 1'b1);
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R6 busy length", n, 16);
    endtask

    task automatic t_read();
        logic exp;
        wr_nib(4'hC, 1'b0);
        host_rd = 1'b1; exp = busy;
        @(negedge clk);
        host_rd = 1'b0;
        check("R5 read mid-pair", host_rdata, {exp, 3'b000});
        wr_nib(4'h3, 1'b0);
        check("R5 pair intact after read", byte_out, 8'hC3);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R5 read busy", host_rdata, 4'h8);
        @(negedge clk);
        check("R5 zero without strobe", host_rdata, 0);
        wait_idle();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R5 read idle", host_rdata, 0);
    endtask

    task automatic t_ignore();
        wr_nib(4'h9, 1'b0);
        wr_nib(4'h9, 1'b0);
        check("R9 err clear before drop", err_flag, 0);
        wr_nib(4'hF, 1'b1);
        check("R8 no vld on dropped write", byte_vld, 0);
        check("R9 err set", err_flag, 1);
        wait_idle();
        wr_nib(4'h3, 1'b0);
        check("R8 phase unchanged", byte_vld, 0);
        wr_nib(4'hC, 1'b1);
        check("R10 next pair", byte_out, 8'h3C);
        check("R10 vld", byte_vld, 1);
        wait_idle();
        check("R9 err sticky", err_flag, 1);
        do_reset();
        check("R1 err cleared by reset", err_flag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_pair_cmd();
        t_pair_char();
        t_busy_len();
        t_read();
        t_ignore();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule